// File: doc/BRIEF.md
# Odd-Ones After Double-Zero Detector

This block watches a one-bit serial input that is sampled on every rising clock edge. It raises its output when two things are both true: the number of 1s received since the last reset is odd, and at some point since that reset the input was 0 on two clock edges in a row. The double-zero condition is sticky and is only cleared by reset. The parity of the 1s is tracked the whole time.

The design is a six-state Moore machine. Four states cover the phase before a double zero: even or odd parity, each with or without one pending 0. Two states cover the phase after it: even and odd. The output is decoded from the registered state alone, so it responds one clock after the input that decides it. A parameter selects how the state is stored, either as a dense 3-bit binary code or as a 6-bit one-hot vector. Both choices behave identically at the ports.

Top module: `parity_dz_detector`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the machine in the even-parity, no-zeros state, and z reads 0 in the cycle that follows.
- R2: After each rising edge, z is 1 exactly when the count of 1s sampled since reset is odd and two consecutive 0s have been sampled since reset; otherwise z is 0.
- R3: Before a double zero has been seen, a sampled 1 toggles parity and cancels any single pending 0, so the pattern 0,1,0 does not count as a double zero.
- R4: A second consecutive sampled 0 moves the machine into the post-double-zero phase without changing parity, so z rises one cycle after that 0 when the 1-count is odd.
- R5: In the post-double-zero phase, sampled 0s leave z unchanged, and the phase is never left except by reset.
- R6: In the post-double-zero phase, each sampled 1 inverts z on the following cycle.
- R7: z is a function of the stored state only: changing x between clock edges does not change z.
- R8: The storage parameter STATE_ENC selects binary (0) or one-hot (1) state coding, and the port behaviour is the same for both. In one-hot coding exactly one state bit is set after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit sampled on each rising edge |
| z | output | 1 | High when the 1-count is odd and a double zero has occurred |

## Verification
The properties assume that rst is held high on the first clock edges, so that the state is defined before any check is enabled. They also assume that x is a clean 0 or 1 at each rising edge. The stimulus asserts reset from time zero and drives x only on falling edges. The mid-cycle toggles used for R7 are always restored to a stable value before the next rising edge. Random runs insert occasional resets so that the sticky phase is entered and left many times.

// File: rtl/pzd_pkg.sv
package pzd_pkg;

   // Bit 0 carries parity of the ones; bits [2:1] carry the zero-run phase.
   typedef enum logic [2:0] {
      ST_EVEN_CLR  = 3'd0,
      ST_ODD_CLR   = 3'd1,
      ST_EVEN_PEND = 3'd2,
      ST_ODD_PEND  = 3'd3,
      ST_EVEN_DONE = 3'd4,
      ST_ODD_DONE  = 3'd5
   } pzd_state_e;

   localparam int unsigned NUM_STATES = 6;
   localparam int unsigned CODE_W     = 3;

   localparam int unsigned ENC_BINARY = 0;
   localparam int unsigned ENC_ONEHOT = 1;

   function automatic int unsigned state_width(input int unsigned enc);
      return (enc == ENC_ONEHOT) ? NUM_STATES : CODE_W;
   endfunction

endpackage

// File: rtl/pzd_next.sv
module pzd_next
   import pzd_pkg::*;
(
   input  pzd_state_e cur,
   input  logic       x_in,
   output pzd_state_e nxt
);

   always_comb begin
      nxt = ST_EVEN_CLR;
      unique case (cur)
         ST_EVEN_CLR:  nxt = x_in ? ST_ODD_CLR   : ST_EVEN_PEND;
         ST_ODD_CLR:   nxt = x_in ? ST_EVEN_CLR  : ST_ODD_PEND;
         ST_EVEN_PEND: nxt = x_in ? ST_ODD_CLR   : ST_EVEN_DONE;
         ST_ODD_PEND:  nxt = x_in ? ST_EVEN_CLR  : ST_ODD_DONE;
         ST_EVEN_DONE: nxt = x_in ? ST_ODD_DONE  : ST_EVEN_DONE;
         ST_ODD_DONE:  nxt = x_in ? ST_EVEN_DONE : ST_ODD_DONE;
         default:      nxt = ST_EVEN_CLR;
      endcase
   end

endmodule

// File: rtl/pzd_state_reg.sv
module pzd_state_reg
   import pzd_pkg::*;
#(
   parameter int unsigned STATE_ENC = ENC_BINARY,
   parameter int unsigned STATE_W   = state_width(STATE_ENC)
) (
   input  logic               clk,
   input  logic               rst,
   input  pzd_state_e         nxt,
   output pzd_state_e         cur,
   output logic [STATE_W-1:0] bits_q
);

   generate
      if (STATE_ENC == ENC_ONEHOT) begin : g_onehot
         logic [STATE_W-1:0] oh_q;
         logic [STATE_W-1:0] oh_d;

         always_comb begin
            oh_d = '0;
            oh_d[int'(nxt)] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) oh_q <= STATE_W'(1);
            else     oh_q <= oh_d;
         end

         always_comb begin
            cur = ST_EVEN_CLR;
            for (int i = STATE_W - 1; i >= 0; i--) begin
               if (oh_q[i]) cur = pzd_state_e'(i[CODE_W-1:0]);
            end
         end

         assign bits_q = oh_q;
      end else begin : g_binary
         logic [STATE_W-1:0] bin_q;

         always_ff @(posedge clk) begin
            if (rst) bin_q <= STATE_W'(ST_EVEN_CLR);
            else     bin_q <= STATE_W'(nxt);
         end

         always_comb begin
            if (int'(bin_q) < NUM_STATES) cur = pzd_state_e'(bin_q[CODE_W-1:0]);
            else                          cur = ST_EVEN_CLR;
         end

         assign bits_q = bin_q;
      end
   endgenerate

endmodule

// File: rtl/pzd_out.sv
module pzd_out
   import pzd_pkg::*;
(
   input  pzd_state_e cur,
   output logic       z_out,
   output logic       done_out
);

   always_comb begin
      done_out = (cur == ST_EVEN_DONE) || (cur == ST_ODD_DONE);
      z_out    = (cur == ST_ODD_DONE);
   end

endmodule

// File: rtl/parity_dz_detector.sv
module parity_dz_detector
   import pzd_pkg::*;
#(
   parameter int unsigned STATE_ENC = ENC_BINARY
) (
   input  logic clk,
   input  logic rst,
   input  logic x,
   output logic z
);

   localparam int unsigned STATE_W = state_width(STATE_ENC);

   generate
      if (STATE_ENC != ENC_BINARY && STATE_ENC != ENC_ONEHOT) begin : g_bad_enc
         $error("parity_dz_detector: STATE_ENC must be 0 or 1");
      end
   endgenerate

   pzd_state_e         cur_st;
   pzd_state_e         nxt_st;
   logic [STATE_W-1:0] state_bits;
   logic               in_done;

   pzd_next u_next (
      .cur  (cur_st),
      .x_in (x),
      .nxt  (nxt_st)
   );

   pzd_state_reg #(
      .STATE_ENC (STATE_ENC),
      .STATE_W   (STATE_W)
   ) u_reg (
      .clk    (clk),
      .rst    (rst),
      .nxt    (nxt_st),
      .cur    (cur_st),
      .bits_q (state_bits)
   );

   pzd_out u_out (
      .cur      (cur_st),
      .z_out    (z),
      .done_out (in_done)
   );

endmodule

// File: rtl/pzd_checker.sv
module pzd_checker #(
   parameter int unsigned STATE_ENC = 0,
   parameter int unsigned STATE_W   = 3
) (
   input logic               clk,
   input logic               rst,
   input logic               x,
   input logic               z,
   input logic               in_done,
   input logic [STATE_W-1:0] state_bits
);

   // R1: reset leaves the output low.
   assert_reset_low_R1: assert property (@(posedge clk) rst |=> !z);

   // R2: z can only be high in the post-double-zero phase.
   assert_z_needs_done_R2: assert property (@(posedge clk) disable iff (rst)
      z |-> in_done);

   // R4: two sampled zeros in a row reach the post-double-zero phase.
   assert_two_zeros_R4: assert property (@(posedge clk) disable iff (rst)
      (!x ##1 !x) |=> in_done);

   // R5: the phase is sticky, and zeros hold z high.
   assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      in_done |=> in_done);
   assert_zero_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (z && !x) |=> z);

   // R6: a one inverts z once the phase is reached.
   assert_one_toggles_R6: assert property (@(posedge clk) disable iff (rst)
      (in_done && x) |=> (z != $past(z)));

   // R8: state storage stays within legal codes.
   generate
      if (STATE_ENC == 1) begin : g_oh_chk
         assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
            $countones(state_bits) == 1);
      end else begin : g_bin_chk
         assert_legal_code_R8: assert property (@(posedge clk) disable iff (rst)
            int'(state_bits) < 6);
      end
   endgenerate

endmodule

bind parity_dz_detector pzd_checker #(
   .STATE_ENC (STATE_ENC),
   .STATE_W   (STATE_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .x          (x),
   .z          (z),
   .in_done    (in_done),
   .state_bits (state_bits)
);

// File: tb/parity_dz_detector_tb.sv
`timescale 1ns/1ps
module parity_dz_detector_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic z_bin, z_oh;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   // reference model state
   bit m_par, m_last0, m_seen;

   always #5 clk = ~clk;

   parity_dz_detector #(.STATE_ENC(0)) u_dut (
      .clk(clk), .rst(rst), .x(x), .z(z_bin));

   parity_dz_detector #(.STATE_ENC(1)) u_dut_oh (
      .clk(clk), .rst(rst), .x(x), .z(z_oh));

   function automatic bit model_z(bit par, bit seen);
      return par & seen;
   endfunction

   task automatic chk(string req, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
      end
   endtask

   task automatic model_step(bit r, bit b);
      if (r) begin
         m_par = 0; m_last0 = 0; m_seen = 0;
      end else if (b) begin
         m_par = ~m_par; m_last0 = 0;
      end else begin
         if (m_last0) m_seen = 1;
         m_last0 = 1;
      end
   endtask

   // drive at falling edge, update model at rising edge, check 2 ns later
   task automatic step(bit r, bit b, string req);
      @(negedge clk);
      rst = r; x = b;
      @(posedge clk);
      model_step(r, b);
      #2;
      chk(req, z_bin, model_z(m_par, m_seen));
      chk({req, "/R8"}, z_oh, z_bin);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic zs;
      // R1: reset state
      step(1, 0, "R1"); step(1, 1, "R1");
      chk("R1", z_bin, 1'b0);
      // R3: 0,1,0 is not a double zero (odd ones, z stays 0)
      step(0, 0, "R3"); step(0, 1, "R3"); step(0, 0, "R3");
      chk("R3", z_bin, 1'b0);
      step(0, 1, "R3"); step(0, 1, "R3");
      // R4: now odd; second zero raises z next cycle
      step(0, 0, "R4");
      chk("R4", z_bin, 1'b0);
      step(0, 0, "R4");
      chk("R4", z_bin, 1'b1);
      // R5: zeros keep z high
      for (int i = 0; i < 5; i++) step(0, 0, "R5");
      chk("R5", z_bin, 1'b1);
      // R6: ones toggle
      step(0, 1, "R6"); chk("R6", z_bin, 1'b0);
      step(0, 1, "R6"); chk("R6", z_bin, 1'b1);
      // R5: phase survives ones then zeros
      step(0, 1, "R5"); step(0, 0, "R5"); step(0, 0, "R5");
      chk("R5", z_bin, 1'b0);
      step(0, 1, "R5"); chk("R5", z_bin, 1'b1);
      // R7: toggling x mid-cycle does not move z
      zs = z_bin;
      x = ~x; #1; chk("R7", z_bin, zs);
      x = ~x; #1; chk("R7", z_bin, zs);
      // R1: reset from the sticky phase
      step(1, 1, "R1"); chk("R1", z_bin, 1'b0);
      // R4: even parity double zero keeps z low, then one raises it
      step(0, 0, "R4"); step(0, 0, "R4"); chk("R4", z_bin, 1'b0);
      step(0, 1, "R6"); chk("R6", z_bin, 1'b1);
      // R2: random stimulus with occasional reset
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 4000; i++) begin
         bit r, b;
         r = ($urandom % 64) == 0;
         b = ($urandom % 100) < (((i / 500) % 2 == 0) ? 35 : 65);
         step(r, b, "R2");
      end
      finish_run();
   end

endmodule